// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel that copies a run of items from one memory region to another. Software fills five word registers through a simple register port: a source pointer, a destination pointer, a chain pointer that must stay zero, a control word and a configuration word. Setting the enable bit starts the copy. The engine then moves one item at a time over a request/acknowledge memory master port. It reads the item at the source pointer, writes it at the destination pointer and then advances each pointer by the item width if that pointer's step bit is set.

When the last item has been written, the hardware clears both the enable bit and the read-only busy flag. Software polls the configuration word until both read as zero. A halt bit pauses the channel between items without losing its place. Two interrupt outputs report completion and configuration errors. Each is gated by its own mask bit and each is held until software writes the configuration word.

Top module: `dma_m2m_chan`

## Requirements
- R1: After reset, every register reads zero, `mem_req`, `tc_irq` and `err_irq` are low, and the channel is not busy.
- R2: Register indices are 0 source pointer, 1 destination pointer, 2 chain pointer, 3 control, 4 configuration, and written values read back. Control fields: [11:0] item count, [14:12] source burst code, [17:15] destination burst code, [20:18] source width code, [23:21] destination width code, [26] source step, [27] destination step. Configuration fields: [0] enable, [13:11] flow type, [14] error interrupt allow, [15] completion interrupt allow, [17] busy, [18] halt.
- R3: With enable set and a valid setup, the engine copies exactly `count` items. Each item is read and then written, and the destination ends up holding the source data.
- R4: Width codes 0, 1 and 2 mean 1, 2 and 4 byte items. The byte strobes select the lanes of the item at the address rounded down to the item size. Address bits below the item size are ignored.
- R5: A pointer whose step bit is set advances by the item size after each item. A pointer whose step bit is clear keeps its value for the whole run.
- R6: After the last write is acknowledged, enable and busy both read zero, the count field reads zero, and the pointers hold their final values.
- R7: Any of the following is a configuration error: a flow type other than 0, unequal source and destination width codes, a width code above 2, or a nonzero chain pointer. On such an error the engine raises the error flag, clears enable and issues no memory request.
- R8: While halt is set, no new read is issued. A read that is already in flight still completes its write. Busy stays high until halt is cleared, and the run then finishes normally.
- R9: The completion flag is set when the count reaches zero, including a start with a count of zero, which makes no memory access. `tc_irq` follows the flag gated by configuration bit 15. The flag stays set until the configuration word is written.
- R10: `err_irq` follows the error flag gated by configuration bit 14. The flag stays set until the configuration word is written.
- R11: The busy bit (configuration bit 17) is read-only, and writing a 1 to it has no effect.
- R12: Once `mem_req` rises, it stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte-lane strobes |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| tc_irq | output | 1 | Completion interrupt |
| err_irq | output | 1 | Configuration error interrupt |

## Verification
The hardest case to reach is a halt that lands while a read is outstanding. In that case the engine must finish the paired write, stop before the next read and keep busy high. The bench waits until a few items have been written on a long 32-bit run. It then sets halt while the memory model is adding random acknowledge delays, so the halt often falls inside a read. Afterwards it checks that the counts of reads and writes match and stay frozen until halt is released.

The byte-lane placement is exercised by random runs of all three widths at unaligned source and destination offsets. Each run's memory image is compared against a byte-wise copy model kept in the bench.

// File: rtl/dma_m2m_pkg.sv
package dma_m2m_pkg;
  localparam int CNT_W    = 12;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;

  localparam int IDX_SRC  = 0;
  localparam int IDX_DST  = 1;
  localparam int IDX_LINK = 2;
  localparam int IDX_CTRL = 3;
  localparam int IDX_CFG  = 4;

  localparam int CTL_SSTEP = 26;
  localparam int CTL_DSTEP = 27;
  localparam int CFG_EN    = 0;
  localparam int CFG_ERRA  = 14;
  localparam int CFG_TCA   = 15;
  localparam int CFG_BUSY  = 17;
  localparam int CFG_HALT  = 18;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_HOLD = 2'd1,
    XS_READ = 2'd2,
    XS_WRITE = 2'd3
  } xfer_state_e;

  function automatic logic [2:0] item_bytes(input logic [2:0] code);
    case (code)
      3'd0:    item_bytes = 3'd1;
      3'd1:    item_bytes = 3'd2;
      3'd2:    item_bytes = 3'd4;
      default: item_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] lane_off(input logic [2:0] code, input logic [1:0] lo);
    case (code)
      3'd0:    lane_off = lo;
      3'd1:    lane_off = {lo[1], 1'b0};
      default: lane_off = 2'b00;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] code);
    case (code)
      3'd0:    lane_mask = 4'b0001;
      3'd1:    lane_mask = 4'b0011;
      3'd2:    lane_mask = 4'b1111;
      default: lane_mask = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/dma_lane_align.sv
module dma_lane_align
  import dma_m2m_pkg::*;
(
  input  logic [2:0]        wcode,
  input  logic [1:0]        rd_lo,
  input  logic [1:0]        wr_lo,
  input  logic              is_write,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] item_in,
  output logic [DATA_W-1:0] item_out,
  output logic [DATA_W-1:0] wr_word,
  output logic [LANES-1:0]  strobe
);
  logic [1:0]        rd_off;
  logic [1:0]        wr_off;
  logic [DATA_W-1:0] keep;

  always_comb begin
    rd_off = lane_off(wcode, rd_lo);
    wr_off = lane_off(wcode, wr_lo);
    for (int b = 0; b < LANES; b++) begin
      keep[8*b +: 8] = {8{lane_mask(wcode)[b]}};
    end
    item_out = (rd_word >> {rd_off, 3'b000}) & keep;
    wr_word  = item_in << {wr_off, 3'b000};
    strobe   = lane_mask(wcode) << (is_write ? wr_off : rd_off);
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_m2m_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              hw_step,
  input  logic [2:0]        step_bytes,
  input  logic              hw_clr_en,
  input  logic              tc_set,
  input  logic              err_set,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] link_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic              tc_flag_q,
  output logic              err_flag_q
);
  localparam logic [DATA_W-1:0] CFG_WMASK = ~(DATA_W'(1) << CFG_BUSY);

  logic [ADDR_W-1:0] src_d, dst_d, link_d;
  logic [DATA_W-1:0] ctrl_d, cfg_d;
  logic              tc_flag_d, err_flag_d;
  logic              cfg_wr;

  assign cfg_wr = wr && (idx == 3'(IDX_CFG));

  always_comb begin
    src_d      = src_q;
    dst_d      = dst_q;
    link_d     = link_q;
    ctrl_d     = ctrl_q;
    cfg_d      = cfg_q;
    tc_flag_d  = tc_flag_q;
    err_flag_d = err_flag_q;
    if (wr) begin
      case (idx)
        3'(IDX_SRC):  src_d  = wdata[ADDR_W-1:0];
        3'(IDX_DST):  dst_d  = wdata[ADDR_W-1:0];
        3'(IDX_LINK): link_d = wdata[ADDR_W-1:0];
        3'(IDX_CTRL): ctrl_d = wdata;
        3'(IDX_CFG):  cfg_d  = wdata & CFG_WMASK;
        default: ;
      endcase
    end
    if (cfg_wr) begin
      tc_flag_d  = 1'b0;
      err_flag_d = 1'b0;
    end
    if (hw_step) begin
      if (ctrl_q[CTL_SSTEP]) src_d = src_q + ADDR_W'(step_bytes);
      if (ctrl_q[CTL_DSTEP]) dst_d = dst_q + ADDR_W'(step_bytes);
      ctrl_d[CNT_W-1:0] = ctrl_q[CNT_W-1:0] - 1'b1;
    end
    if (hw_clr_en) cfg_d[CFG_EN] = 1'b0;
    if (tc_set)    tc_flag_d  = 1'b1;
    if (err_set)   err_flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= '0;
      dst_q      <= '0;
      link_q     <= '0;
      ctrl_q     <= '0;
      cfg_q      <= '0;
      tc_flag_q  <= 1'b0;
      err_flag_q <= 1'b0;
    end else begin
      src_q      <= src_d;
      dst_q      <= dst_d;
      link_q     <= link_d;
      ctrl_q     <= ctrl_d;
      cfg_q      <= cfg_d;
      tc_flag_q  <= tc_flag_d;
      err_flag_q <= err_flag_d;
    end
  end

  always_comb begin
    case (idx)
      3'(IDX_SRC):  rdata = DATA_W'(src_q);
      3'(IDX_DST):  rdata = DATA_W'(dst_q);
      3'(IDX_LINK): rdata = DATA_W'(link_q);
      3'(IDX_CTRL): rdata = ctrl_q;
      3'(IDX_CFG):  rdata = cfg_q | (DATA_W'(busy) << CFG_BUSY);
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dma_m2m_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic halt,
  input  logic setup_ok,
  input  logic cnt_zero,
  input  logic cnt_one,
  input  logic mem_ack,
  output logic busy,
  output logic req,
  output logic we,
  output logic rd_cap,
  output logic hw_step,
  output logic hw_clr_en,
  output logic tc_set,
  output logic err_set
);
  xfer_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    rd_cap    = 1'b0;
    hw_step   = 1'b0;
    hw_clr_en = 1'b0;
    tc_set    = 1'b0;
    err_set   = 1'b0;
    case (st_q)
      XS_IDLE: begin
        if (en) begin
          if (!setup_ok) begin
            err_set   = 1'b1;
            hw_clr_en = 1'b1;
          end else if (cnt_zero) begin
            tc_set    = 1'b1;
            hw_clr_en = 1'b1;
          end else begin
            st_d = halt ? XS_HOLD : XS_READ;
          end
        end
      end
      XS_HOLD: if (!halt) st_d = XS_READ;
      XS_READ: begin
        if (mem_ack) begin
          rd_cap = 1'b1;
          st_d   = XS_WRITE;
        end
      end
      XS_WRITE: begin
        if (mem_ack) begin
          hw_step = 1'b1;
          if (cnt_one) begin
            hw_clr_en = 1'b1;
            tc_set    = 1'b1;
            st_d      = XS_IDLE;
          end else begin
            st_d = halt ? XS_HOLD : XS_READ;
          end
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= XS_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != XS_IDLE);
  assign req  = (st_q == XS_READ) || (st_q == XS_WRITE);
  assign we   = (st_q == XS_WRITE);
endmodule

// File: rtl/dma_m2m_chan.sv
module dma_m2m_chan
  import dma_m2m_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              tc_irq,
  output logic              err_irq
);
  logic              rst_meta_q, rst_q;
  logic [ADDR_W-1:0] src_q, dst_q, link_q;
  logic [DATA_W-1:0] ctrl_q, cfg_q;
  logic              tc_flag_q, err_flag_q;
  logic              active, rd_cap, hw_step, hw_clr_en, tc_set, err_set;
  logic              setup_ok;
  logic [2:0]        wcode;
  logic [DATA_W-1:0] item_q, item_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  assign wcode    = ctrl_q[20:18];
  assign setup_ok = (cfg_q[13:11] == 3'd0) && (ctrl_q[20:18] == ctrl_q[23:21])
                    && (wcode <= 3'd2) && (link_q == '0);

  dma_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_q),
    .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
    .busy(active), .hw_step(hw_step), .step_bytes(item_bytes(wcode)),
    .hw_clr_en(hw_clr_en), .tc_set(tc_set), .err_set(err_set),
    .src_q(src_q), .dst_q(dst_q), .link_q(link_q), .ctrl_q(ctrl_q), .cfg_q(cfg_q),
    .tc_flag_q(tc_flag_q), .err_flag_q(err_flag_q)
  );

  dma_xfer_ctl u_ctl (
    .clk(clk), .rst_n(rst_q),
    .en(cfg_q[CFG_EN]), .halt(cfg_q[CFG_HALT]), .setup_ok(setup_ok),
    .cnt_zero(ctrl_q[CNT_W-1:0] == '0), .cnt_one(ctrl_q[CNT_W-1:0] == CNT_W'(1)),
    .mem_ack(mem_ack), .busy(active), .req(mem_req), .we(mem_we),
    .rd_cap(rd_cap), .hw_step(hw_step), .hw_clr_en(hw_clr_en),
    .tc_set(tc_set), .err_set(err_set)
  );

  dma_lane_align u_lanes (
    .wcode(wcode), .rd_lo(src_q[1:0]), .wr_lo(dst_q[1:0]), .is_write(mem_we),
    .rd_word(mem_rdata), .item_in(item_q), .item_out(item_next),
    .wr_word(mem_wdata), .strobe(mem_be)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      item_q <= '0;
    else if (rd_cap) item_q <= item_next;
  end

  assign mem_addr = mem_we ? dst_q : src_q;
  assign tc_irq   = tc_flag_q  && cfg_q[CFG_TCA];
  assign err_irq  = err_flag_q && cfg_q[CFG_ERRA];
endmodule

// File: rtl/dma_m2m_chan_chk.sv
module dma_m2m_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [2:0]        wcode,
  input logic              halt,
  input logic              active,
  input logic              reg_wr,
  input logic [2:0]        reg_idx,
  input logic              tc_irq,
  input logic              err_irq
);
  logic cfg_touch;
  assign cfg_touch = reg_wr && (reg_idx == 3'd4);

  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_be) == int'(dma_m2m_pkg::item_bytes(wcode)));

  assert_halt_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !(mem_req && !mem_we) |=> !(mem_req && !mem_we));

  assert_idle_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req);

  assert_tc_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq && !cfg_touch |=> tc_irq);

  assert_err_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq && !cfg_touch |=> err_irq);
endmodule

bind dma_m2m_chan dma_m2m_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_be(mem_be), .wcode(wcode), .halt(cfg_q[18]),
  .active(active), .reg_wr(reg_wr), .reg_idx(reg_idx), .tc_irq(tc_irq), .err_irq(err_irq)
);

// File: tb/dma_m2m_chan_bench.sv
`timescale 1ns/1ps
module dma_m2m_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        tc_irq, err_irq;

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, req_cycles = 0;
  logic [31:0] mem [0:63];
  logic [7:0]  exp_b [0:255];

  always #2 clk = ~clk;

  dma_m2m_chan u_dma_m2m_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .tc_irq(tc_irq), .err_irq(err_irq)
  );

  // Memory model: answers on the falling edge after a random wait
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      req_cycles++;
      if ($urandom_range(0, 2) != 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] = mem_wdata[8*b +: 8];
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[7:2]];
          rd_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    reg_idx = i;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] c;
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      reg_read(3'd4, c);
      if (!c[0] && !c[17]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic int wbytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  task automatic fill_mem();
    for (int w = 0; w < 64; w++) begin
      mem[w] = $urandom;
      for (int b = 0; b < 4; b++) exp_b[4*w+b] = mem[w][8*b +: 8];
    end
  endtask

  task automatic model_copy(input int s, input int d, input int n, input int code, input bit si, input bit di);
    int w;
    w = wbytes(code);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < w; k++)
        exp_b[((d & ~(w-1)) + k) & 255] = exp_b[((s & ~(w-1)) + k) & 255];
      if (si) s += w;
      if (di) d += w;
    end
  endtask

  function automatic int mem_mismatch();
    int bad;
    bad = 0;
    for (int w = 0; w < 64; w++)
      if (mem[w] != {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]}) bad++;
    return bad;
  endfunction

  function automatic logic [31:0] mk_ctrl(input int n, input int sc, input int dc, input bit si, input bit di);
    return 32'(n & 12'hFFF) | (32'(3'd2) << 12) | (32'(3'd1) << 15)
           | (32'(sc) << 18) | (32'(dc) << 21) | (32'(si) << 26) | (32'(di) << 27);
  endfunction

  task automatic run_copy(input int s, input int d, input int n, input int code,
                          input bit si, input bit di, input bit tca, input string tag);
    logic [31:0] v;
    bit ok;
    int w;
    w = wbytes(code);
    fill_mem();
    model_copy(s, d, n, code, si, di);
    reg_write(3'd0, 32'(s));
    reg_write(3'd1, 32'(d));
    reg_write(3'd2, 32'd0);
    reg_write(3'd3, mk_ctrl(n, code, code, si, di));
    reg_write(3'd4, 32'h1 | (32'(tca) << 15));
    wait_done(ok);
    chk(ok, {tag, " R6 enable/busy clear"}, 32'(ok), 32'd1);
    chk(mem_mismatch() == 0, {tag, " R3 R4 memory image"}, 32'(mem_mismatch()), 32'd0);
    reg_read(3'd0, v);
    chk(v == 32'(si ? s + n*w : s), {tag, " R5 source pointer"}, v, 32'(si ? s + n*w : s));
    reg_read(3'd1, v);
    chk(v == 32'(di ? d + n*w : d), {tag, " R5 dest pointer"}, v, 32'(di ? d + n*w : d));
    reg_read(3'd3, v);
    chk(v[11:0] == 12'd0, {tag, " R6 count zero"}, 32'(v[11:0]), 32'd0);
    chk(tc_irq == tca, {tag, " R9 tc_irq gating"}, 32'(tc_irq), 32'(tca));
  endtask

  task automatic bad_setup(input logic [31:0] ctrl, input logic [31:0] link, input logic [31:0] cfgx, input string tag);
    logic [31:0] v;
    int r0;
    r0 = req_cycles;
    reg_write(3'd2, link);
    reg_write(3'd3, ctrl);
    reg_write(3'd4, 32'h1 | cfgx | (32'd1 << 14));
    repeat (5) @(negedge clk);
    reg_read(3'd4, v);
    chk(v[0] == 1'b0 && v[17] == 1'b0, {tag, " R7 enable cleared"}, v, 32'd0);
    chk(req_cycles == r0 && rd_cnt >= 0, {tag, " R7 no memory request"}, 32'(req_cycles - r0), 32'd0);
    chk(err_irq == 1'b1, {tag, " R10 err_irq raised"}, 32'(err_irq), 32'd1);
    reg_write(3'd2, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    int r0, w0, rr, ww;
    void'($urandom(32'd20240611));
    reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0; mem_ack = 1'b0; mem_rdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      reg_read(3'(i), v);
      chk(v == 32'd0, "R1 register reset", v, 32'd0);
    end
    chk(!mem_req && !tc_irq && !err_irq, "R1 outputs low", {mem_req, tc_irq, err_irq}, 32'd0);

    // R2 readback, R11 busy bit read-only
    reg_write(3'd3, 32'h0A5A_7123);
    reg_read(3'd3, v);
    chk(v == 32'h0A5A_7123, "R2 control readback", v, 32'h0A5A_7123);
    reg_write(3'd2, 32'h0000_0040);
    reg_read(3'd2, v);
    chk(v == 32'h40, "R2 chain pointer readback", v, 32'h40);
    reg_write(3'd2, 32'd0);
    reg_write(3'd4, 32'h0002_C000);
    reg_read(3'd4, v);
    chk(v == 32'h0000_C000, "R11 busy bit ignores writes", v, 32'h0000_C000);

    // Directed copies
    run_copy(8'h10, 8'h90, 4, 2, 1, 1, 1, "w32 aligned");
    run_copy(8'h06, 8'h8A, 3, 1, 1, 1, 1, "w16 offset");
    run_copy(8'h03, 8'hC5, 5, 0, 1, 1, 0, "w8 masked");
    run_copy(8'h20, 8'hA0, 6, 2, 0, 1, 1, "fixed source");
    run_copy(8'h21, 8'hB3, 4, 0, 1, 0, 1, "fixed dest");
    run_copy(8'h05, 8'h92, 2, 1, 1, 1, 1, "w16 unaligned low bit");

    // Random copies
    for (int t = 0; t < 10; t++) begin
      int code, n, s, d;
      code = $urandom_range(0, 2);
      n = $urandom_range(1, 12);
      s = $urandom_range(0, 15);
      d = 128 + $urandom_range(0, 15);
      if (code != 0) begin s = s & ~(wbytes(code) - 1); d = d & ~(wbytes(code) - 1); end
      run_copy(s, d, n, code, 1'($urandom), 1'($urandom), 1'($urandom), "random");
    end

    // R9 hold until configuration write
    reg_write(3'd3, 32'd0);
    reg_write(3'd4, 32'h0000_8001);
    repeat (3) @(negedge clk);
    chk(tc_irq == 1'b1, "R9 zero count sets completion", 32'(tc_irq), 32'd1);
    repeat (10) @(negedge clk);
    chk(tc_irq == 1'b1, "R9 completion held", 32'(tc_irq), 32'd1);
    reg_write(3'd4, 32'h0000_8000);
    chk(tc_irq == 1'b0, "R9 cleared by configuration write", 32'(tc_irq), 32'd0);

    // R7 error setups
    bad_setup(mk_ctrl(4, 1, 2, 1, 1), 32'd0, 32'd0, "width mismatch");
    bad_setup(mk_ctrl(4, 3, 3, 1, 1), 32'd0, 32'd0, "width code 3");
    bad_setup(mk_ctrl(4, 2, 2, 1, 1), 32'd0, 32'h0000_0800, "flow type 1");
    bad_setup(mk_ctrl(4, 2, 2, 1, 1), 32'h0000_0010, 32'd0, "chain pointer");
    reg_write(3'd4, 32'd0);
    chk(err_irq == 1'b0, "R10 cleared by configuration write", 32'(err_irq), 32'd0);
    reg_write(3'd3, mk_ctrl(4, 1, 2, 1, 1));
    reg_write(3'd4, 32'h0000_0001);
    repeat (4) @(negedge clk);
    chk(err_irq == 1'b0, "R10 masked error stays low", 32'(err_irq), 32'd0);

    // R8 halt before start
    fill_mem();
    model_copy(8'h00, 8'h80, 3, 2, 1, 1);
    reg_write(3'd0, 32'h00);
    reg_write(3'd1, 32'h80);
    reg_write(3'd3, mk_ctrl(3, 2, 2, 1, 1));
    r0 = req_cycles;
    reg_write(3'd4, 32'h0004_8001);
    repeat (20) @(negedge clk);
    reg_read(3'd4, v);
    chk(v[17] == 1'b1, "R8 busy while halted", v, 32'h0002_0000);
    chk(req_cycles == r0, "R8 no access while halted", 32'(req_cycles - r0), 32'd0);
    reg_write(3'd4, 32'h0000_8001);
    wait_done(ok);
    chk(ok && mem_mismatch() == 0, "R8 finishes after release", 32'(mem_mismatch()), 32'd0);

    // R8 halt during a run
    fill_mem();
    model_copy(8'h00, 8'h80, 12, 2, 1, 1);
    reg_write(3'd0, 32'h00);
    reg_write(3'd1, 32'h80);
    reg_write(3'd3, mk_ctrl(12, 2, 2, 1, 1));
    w0 = wr_cnt;
    reg_write(3'd4, 32'h0000_8001);
    for (int n = 0; n < 500 && wr_cnt < w0 + 2; n++) @(negedge clk);
    reg_write(3'd4, 32'h0004_8001);
    repeat (30) @(negedge clk);
    rr = rd_cnt; ww = wr_cnt;
    chk(rr == ww, "R8 in-flight read completes its write", 32'(ww), 32'(rr));
    repeat (30) @(negedge clk);
    chk(rd_cnt == rr, "R8 no new read while halted", 32'(rd_cnt), 32'(rr));
    reg_read(3'd4, v);
    chk(v[17] == 1'b1 && v[0] == 1'b1, "R8 busy and enable held", v, 32'h0006_8001);
    reg_write(3'd4, 32'h0000_8001);
    wait_done(ok);
    chk(ok && mem_mismatch() == 0, "R8 mid-run halt result", 32'(mem_mismatch()), 32'd0);
    chk(tc_irq == 1'b1, "R9 completion after halted run", 32'(tc_irq), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule